// File: doc/BRIEF.md
# Oscillator Frequency Error Trimmer

This block measures the frequency error of a local oscillator against a slow reference sync pulse, and can correct the oscillator's trim code by itself. A counter clocked by the oscillator is loaded with a reload value at every sync event. It counts down to zero and then counts up until the next sync arrives. The value it holds when the sync arrives, and the direction it was counting in, are latched as the measured error. When the reload value equals (oscillator frequency / sync frequency) - 1, a perfect oscillator produces a capture of zero.

The sync event can come from one of three inputs, chosen by a source field: the board pin, the low-speed crystal, or the USB start-of-frame pulse. The chosen input passes through a polarity select and then a power-of-two event prescaler. A software write can also produce a sync event. Each capture is graded against an error limit, and the result sets one of the status flags. With automatic trimming enabled, the same grading steps a saturating 6-bit trim code toward the target. Software uses a four-word register port: control, configuration, status and a write-one-to-clear register. A single interrupt line signals any flag whose interrupt is enabled.

Top module: `clk_trim_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_2000 (trim code 32, everything disabled). The configuration word reads 0x2022_BB7F (reload 0xBB7F, limit 0x22, prescale code 0, source 2, rising polarity). Status reads 0, trim_code is 32 and irq is 0.
- R2: Address 1 is the configuration word: reload at bits 15:0, limit at 23:16, prescale code at 26:24, source at 29:28 and polarity at bit 31. A write to it takes effect only while counting is disabled. While the enable bit (control bit 0) is set, such a write leaves it unchanged.
- R3: A sync event loads the reload value R and starts a down count. Reaching zero sets the expected-sync flag (status bit 3), and the count then turns upward. For events M cycles apart, the capture (status 31:16) is |M-(R+1)|. The direction bit (status 15) is 1 for M <= R+1, which means a slow oscillator, and 0 otherwise.
- R4: A capture at or below the limit sets the in-range flag (status bit 0) and leaves the trim code unchanged.
- R5: A capture above the limit but below three times the limit sets the warning flag (status bit 1). With auto-trim enabled (control bit 1), it moves the trim code one step: up when the direction bit is 1, down when it is 0.
- R6: A capture of three times the limit or more sets the sync-error source (status bit 8). With auto-trim enabled, it moves the trim code two steps in the same sense as R5.
- R7: While counting up, a count that reaches three times the limit sets the missed-sync source (status bit 9). The counter then holds that value until the next event.
- R8: A trim step that would leave 0..63 saturates the trim code at the bound and sets the trim-overflow source (status bit 10).
- R9: While auto-trim is enabled, the trim field written at control bits 13:8 is ignored.
- R10: Status bit 2 is the OR of bits 8, 9 and 10. Flags clear only when 1 is written to the matching bit at address 3 (bit 0 in-range, bit 1 warning, bit 3 expected-sync). Writing bit 2 clears all three error sources and leaves the other flags alone.
- R11: The source code selects the sync input (0 pin, 1 low-speed crystal, 2 start-of-frame). The other inputs have no effect. Polarity 1 makes falling edges the active ones.
- R12: Prescale code k produces one sync event for every 2^k active edges.
- R13: Writing 1 to control bit 2 while counting is enabled produces one sync event at that write, without passing through the prescaler.
- R14: irq is high exactly when a flag is set whose enable is set. The enables sit at control bits 4..7 and apply to in-range, warning, error and expected-sync in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin | input | 1 | Sync from the board pin |
| sync_lsx | input | 1 | Sync from the low-speed crystal |
| sync_sof | input | 1 | USB start-of-frame pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 config, 2 status, 3 clear |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| trim_code | output | 6 | Oscillator trim code |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker watches several rules on every cycle. It checks that the configuration stays frozen while counting runs and that the trim code is steady under auto-trim except at a sync event. It also checks that a saturating step lands on a bound, that an error clear empties all three error sources, and that expected-sync only fires while counting down. It further checks that the counter holds while a miss is flagged and that irq never rises without a flag. The grading itself can only be shown by the bench's scenarios. These drive sync edges at controlled spacings and compare the capture value, direction, flags and trim steps with values worked out from the spacing. The same applies to source and polarity selection, the prescaler ratio and the software sync.

// File: rtl/clk_trim_pkg.sv
package clk_trim_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_CLR  = 2'd3;

  // control word bit positions
  localparam int C_EN      = 0;
  localparam int C_AUTO    = 1;
  localparam int C_SW      = 2;
  localparam int C_IE_LO   = 4;
  localparam int C_TRIM_LO = 8;

  // status and clear word bit positions
  localparam int S_OK    = 0;
  localparam int S_WARN  = 1;
  localparam int S_ERR   = 2;
  localparam int S_ESYNC = 3;
  localparam int S_SERR  = 8;
  localparam int S_MISS  = 9;
  localparam int S_TOVF  = 10;
  localparam int S_DIR   = 15;

  typedef enum logic [1:0] {CLS_OK = 2'd0, CLS_WARN = 2'd1, CLS_ERR = 2'd2} cls_e;
endpackage

// File: rtl/clk_trim_sync.sv
module clk_trim_sync #(
  parameter int DW   = 3,
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NSRC-1:0] raw,
  input  logic [1:0]      src,
  input  logic            pol,
  input  logic [DW-1:0]   div,
  input  logic            sw_sync,
  output logic            evt
);
  localparam int PW = (1 << DW) - 1;

  logic          picked, lvl, prev_q, edge_w, fire;
  logic [PW-1:0] pcnt_q, pcnt_d, mask;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (int'(src) == i) picked = raw[i];
    end
    lvl    = picked ^ pol;
    edge_w = lvl & ~prev_q;
    mask   = ~({PW{1'b1}} << div);
    fire   = en & edge_w & (pcnt_q == mask);
    evt    = fire | (en & sw_sync);
  end

  always_comb begin
    pcnt_d = pcnt_q;
    if (!en)         pcnt_d = '0;
    else if (fire)   pcnt_d = '0;
    else if (edge_w) pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      prev_q <= lvl;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/clk_trim_cnt.sv
module clk_trim_cnt #(
  parameter int CW    = 16,
  parameter int LIM3W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             evt,
  input  logic [CW-1:0]    reload,
  input  logic [LIM3W-1:0] lim3,
  output logic [CW-1:0]    cnt_val,
  output logic             cnt_down,
  output logic             esync_set,
  output logic             miss_set,
  output logic [CW-1:0]    cap_val,
  output logic             cap_dir
);
  logic [CW-1:0] cnt_d, lim3_x;
  logic          down_d;

  assign lim3_x = {{(CW-LIM3W){1'b0}}, lim3};

  always_comb begin
    cnt_d     = cnt_val;
    down_d    = cnt_down;
    esync_set = 1'b0;
    miss_set  = 1'b0;
    if (!en || evt) begin
      cnt_d  = reload;
      down_d = 1'b1;
    end else if (cnt_down) begin
      if (cnt_val == '0) begin
        down_d = 1'b0;
        cnt_d  = {{(CW-1){1'b0}}, 1'b1};
      end else begin
        cnt_d     = cnt_val - 1'b1;
        esync_set = (cnt_val == {{(CW-1){1'b0}}, 1'b1});
      end
    end else if (cnt_val >= lim3_x) begin
      miss_set = 1'b1;
    end else begin
      cnt_d = cnt_val + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_val  <= '0;
      cnt_down <= 1'b1;
    end else begin
      cnt_val  <= cnt_d;
      cnt_down <= down_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val <= '0;
      cap_dir <= 1'b0;
    end else if (en && evt) begin
      cap_val <= cnt_val;
      cap_dir <= cnt_down;
    end
  end
endmodule

// File: rtl/clk_trim_cls.sv
module clk_trim_cls
  import clk_trim_pkg::*;
#(
  parameter int CW    = 16,
  parameter int LW    = 8,
  parameter int LIM3W = 10,
  parameter int TW    = 6
) (
  input  logic [CW-1:0]    val,
  input  logic             down,
  input  logic [LW-1:0]    lim,
  input  logic [LIM3W-1:0] lim3,
  input  logic [TW-1:0]    trim,
  output cls_e             cls,
  output logic [TW-1:0]    trim_nx,
  output logic             ovf
);
  localparam logic [TW+1:0] MAXV = (TW+2)'((1 << TW) - 1);

  logic [TW+1:0] base, step, sum, diff;

  always_comb begin
    if (val <= {{(CW-LW){1'b0}}, lim})            cls = CLS_OK;
    else if (val < {{(CW-LIM3W){1'b0}}, lim3})    cls = CLS_WARN;
    else                                          cls = CLS_ERR;
    case (cls)
      CLS_WARN: step = (TW+2)'(1);
      CLS_ERR:  step = (TW+2)'(2);
      default:  step = '0;
    endcase
    base    = {2'b00, trim};
    sum     = base + step;
    diff    = base - step;
    ovf     = 1'b0;
    trim_nx = trim;
    if (down) begin
      if (sum > MAXV) begin
        trim_nx = MAXV[TW-1:0];
        ovf     = 1'b1;
      end else begin
        trim_nx = sum[TW-1:0];
      end
    end else if (base < step) begin
      trim_nx = '0;
      ovf     = 1'b1;
    end else begin
      trim_nx = diff[TW-1:0];
    end
  end
endmodule

// File: rtl/clk_trim_ctrl.sv
module clk_trim_ctrl
  import clk_trim_pkg::*;
#(
  parameter int             CW         = 16,
  parameter int             LW         = 8,
  parameter int             DW         = 3,
  parameter int             TW         = 6,
  parameter logic [CW-1:0]  RELOAD_RST = 16'hBB7F,
  parameter logic [LW-1:0]  LIM_RST    = 8'h22,
  parameter logic [1:0]     SRC_RST    = 2'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_pin,
  input  logic        sync_lsx,
  input  logic        sync_sof,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [TW-1:0] trim_code,
  output logic        irq
);
  localparam int LIM3W   = LW + 2;
  localparam int LIM_LO  = CW;
  localparam int DIV_LO  = CW + LW;
  localparam int SRC_LO  = DIV_LO + DW + 1;
  localparam int POL_BIT = SRC_LO + 3;
  localparam int CAP_LO  = 32 - CW;
  localparam logic [TW-1:0] TRIM_RST = TW'(1 << (TW - 1));

  // reset: asserted asynchronously, released on the clock
  logic rs_meta, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_s_n <= rs_meta;
    end
  end

  logic             cnt_en_q, auto_q, cnt_en_d, auto_d;
  logic [3:0]       ie_q, ie_d;
  logic [TW-1:0]    trim_q, trim_d;
  logic [CW-1:0]    reload_q;
  logic [LW-1:0]    lim_q;
  logic [DW-1:0]    div_q;
  logic [1:0]       src_q;
  logic             pol_q;
  logic             ok_q, warn_q, esync_q, serr_q, miss_q, tovf_q;
  logic             ok_d, warn_d, esync_d, serr_d, miss_d, tovf_d;
  logic             wr_ctrl, wr_cfg, wr_clr, sw_sync, evt;
  logic             cfg_we, err_any;
  logic [LIM3W-1:0] lim3;
  logic [CW-1:0]    cnt_val, cap_val;
  logic             cnt_down, cap_dir, esync_set, miss_set, ovf_w;
  logic [TW-1:0]    trim_nx;
  cls_e             cls;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_cfg  = bus_wr && (bus_addr == A_CFG);
  assign wr_clr  = bus_wr && (bus_addr == A_CLR);
  assign sw_sync = wr_ctrl && bus_wdata[C_SW];
  assign cfg_we  = wr_cfg && !cnt_en_q;
  assign lim3    = ({2'b00, lim_q} << 1) + {2'b00, lim_q};
  assign err_any = serr_q | miss_q | tovf_q;

  clk_trim_sync #(.DW(DW), .NSRC(3)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .en(cnt_en_q),
    .raw({sync_sof, sync_lsx, sync_pin}), .src(src_q), .pol(pol_q),
    .div(div_q), .sw_sync(sw_sync), .evt(evt)
  );

  clk_trim_cnt #(.CW(CW), .LIM3W(LIM3W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .en(cnt_en_q), .evt(evt),
    .reload(reload_q), .lim3(lim3), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .esync_set(esync_set), .miss_set(miss_set), .cap_val(cap_val), .cap_dir(cap_dir)
  );

  clk_trim_cls #(.CW(CW), .LW(LW), .LIM3W(LIM3W), .TW(TW)) u_cls (
    .val(cnt_val), .down(cnt_down), .lim(lim_q), .lim3(lim3), .trim(trim_q),
    .cls(cls), .trim_nx(trim_nx), .ovf(ovf_w)
  );

  // control next state
  always_comb begin
    cnt_en_d = cnt_en_q;
    auto_d   = auto_q;
    ie_d     = ie_q;
    trim_d   = trim_q;
    if (wr_ctrl) begin
      cnt_en_d = bus_wdata[C_EN];
      auto_d   = bus_wdata[C_AUTO];
      ie_d     = bus_wdata[C_IE_LO +: 4];
      if (!auto_q) trim_d = bus_wdata[C_TRIM_LO +: TW];
    end
    if (auto_q && evt) trim_d = trim_nx;
  end

  // flag next state: clear first, a same-cycle set wins
  always_comb begin
    ok_d    = ok_q;
    warn_d  = warn_q;
    esync_d = esync_q;
    serr_d  = serr_q;
    miss_d  = miss_q;
    tovf_d  = tovf_q;
    if (wr_clr) begin
      if (bus_wdata[S_OK])    ok_d    = 1'b0;
      if (bus_wdata[S_WARN])  warn_d  = 1'b0;
      if (bus_wdata[S_ESYNC]) esync_d = 1'b0;
      if (bus_wdata[S_ERR]) begin
        serr_d = 1'b0;
        miss_d = 1'b0;
        tovf_d = 1'b0;
      end
    end
    if (evt) begin
      case (cls)
        CLS_OK:   ok_d   = 1'b1;
        CLS_WARN: warn_d = 1'b1;
        default:  serr_d = 1'b1;
      endcase
      if (auto_q && ovf_w) tovf_d = 1'b1;
    end
    if (esync_set) esync_d = 1'b1;
    if (miss_set)  miss_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cnt_en_q <= 1'b0;
      auto_q   <= 1'b0;
      ie_q     <= '0;
      trim_q   <= TRIM_RST;
    end else begin
      cnt_en_q <= cnt_en_d;
      auto_q   <= auto_d;
      ie_q     <= ie_d;
      trim_q   <= trim_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      reload_q <= RELOAD_RST;
      lim_q    <= LIM_RST;
      div_q    <= '0;
      src_q    <= SRC_RST;
      pol_q    <= 1'b0;
    end else if (cfg_we) begin
      reload_q <= bus_wdata[CW-1:0];
      lim_q    <= bus_wdata[LIM_LO +: LW];
      div_q    <= bus_wdata[DIV_LO +: DW];
      src_q    <= bus_wdata[SRC_LO +: 2];
      pol_q    <= bus_wdata[POL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ok_q    <= 1'b0;
      warn_q  <= 1'b0;
      esync_q <= 1'b0;
      serr_q  <= 1'b0;
      miss_q  <= 1'b0;
      tovf_q  <= 1'b0;
    end else begin
      ok_q    <= ok_d;
      warn_q  <= warn_d;
      esync_q <= esync_d;
      serr_q  <= serr_d;
      miss_q  <= miss_d;
      tovf_q  <= tovf_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[C_EN]              = cnt_en_q;
        bus_rdata[C_AUTO]            = auto_q;
        bus_rdata[C_IE_LO +: 4]      = ie_q;
        bus_rdata[C_TRIM_LO +: TW]   = trim_q;
      end
      A_CFG: begin
        bus_rdata[CW-1:0]            = reload_q;
        bus_rdata[LIM_LO +: LW]      = lim_q;
        bus_rdata[DIV_LO +: DW]      = div_q;
        bus_rdata[SRC_LO +: 2]       = src_q;
        bus_rdata[POL_BIT]           = pol_q;
      end
      A_STAT: begin
        bus_rdata[S_OK]              = ok_q;
        bus_rdata[S_WARN]            = warn_q;
        bus_rdata[S_ERR]             = err_any;
        bus_rdata[S_ESYNC]           = esync_q;
        bus_rdata[S_SERR]            = serr_q;
        bus_rdata[S_MISS]            = miss_q;
        bus_rdata[S_TOVF]            = tovf_q;
        bus_rdata[S_DIR]             = cap_dir;
        bus_rdata[CAP_LO +: CW]      = cap_val;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign trim_code = trim_q;
  assign irq = |({esync_q, err_any, warn_q, ok_q} & ie_q);
endmodule

// File: rtl/clk_trim_chk.sv
module clk_trim_chk #(
  parameter int CW = 16,
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic          cnt_en_q,
  input logic          auto_q,
  input logic          evt,
  input logic          ovf_w,
  input logic [TW-1:0] trim_q,
  input logic [31:0]   cfg_word,
  input logic          clr_err,
  input logic          miss_set,
  input logic          esync_set,
  input logic          cnt_down,
  input logic [CW-1:0] cnt_val,
  input logic [5:0]    flags,
  input logic          irq
);
  localparam logic [TW-1:0] TMAX = {TW{1'b1}};

  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    cnt_en_q |=> $stable(cfg_word));

  p_trim_hold_auto_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (auto_q && !evt) |=> $stable(trim_q));

  p_trim_sat_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (evt && auto_q && ovf_w) |=> (trim_q == '0 || trim_q == TMAX));

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (clr_err && !evt && !miss_set) |=> (flags[5:3] == 3'b000));

  p_esync_down_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    esync_set |-> cnt_down);

  p_miss_hold_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (miss_set && cnt_en_q) |=> $stable(cnt_val));

  p_irq_flag_r14: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> (flags != 6'b0));
endmodule

bind clk_trim_ctrl clk_trim_chk #(.CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .cnt_en_q(cnt_en_q), .auto_q(auto_q),
  .evt(evt), .ovf_w(ovf_w), .trim_q(trim_q),
  .cfg_word({pol_q, src_q, div_q, lim_q, reload_q}),
  .clr_err(wr_clr && bus_wdata[2]), .miss_set(miss_set), .esync_set(esync_set),
  .cnt_down(cnt_down), .cnt_val(cnt_val),
  .flags({tovf_q, miss_q, serr_q, esync_q, warn_q, ok_q}), .irq(irq)
);

// File: tb/sim_clk_trim_ctrl.sv
module sim_clk_trim_ctrl;
  logic        clk, rst_n;
  logic        sync_pin, sync_lsx, sync_sof;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [5:0]  trim_code;
  logic        irq;
  int          checks, fails;
  bit          done;

  clk_trim_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .sync_lsx(sync_lsx),
    .sync_sof(sync_sof), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trim_code(trim_code), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    case (idx)
      0: sync_pin = ~sync_pin;
      1: sync_lsx = ~sync_lsx;
      default: sync_sof = ~sync_sof;
    endcase
    @(negedge clk);
    case (idx)
      0: sync_pin = ~sync_pin;
      1: sync_lsx = ~sync_lsx;
      default: sync_sof = ~sync_sof;
    endcase
  endtask

  // next event lands m cycles after the previous one; 'used' negedges already spent
  task automatic next_event(input int idx, input int m, input int used);
    settle(m - 1 - used);
    pulse(idx);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk("R1 control reset", v, 32'h0000_2000);
    rd(2'd1, v); chk("R1 config reset", v, 32'h2022_BB7F);
    rd(2'd2, v); chk("R1 status reset", v, 32'h0);
    chk("R1 trim reset", 32'(trim_code), 32'd32);
    chk("R1 irq reset", 32'(irq), 32'd0);
  endtask

  task automatic t_setup;
    logic [31:0] v;
    wr(2'd1, 32'h0002_0009);
    rd(2'd1, v); chk("R2 config write when idle", v, 32'h0002_0009);
    wr(2'd0, 32'h0000_20F1);
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, v); chk("R2 config locked while counting", v, 32'h0002_0009);
    pulse(0);
    wr(2'd3, 32'hF);
    wr(2'd0, 32'h0000_20F3);
  endtask

  task automatic t_exact;
    logic [31:0] v;
    next_event(0, 10, 2);
    rd(2'd2, v); chk("R3 R4 exact spacing status", v, 32'h0000_8009);
    chk("R4 trim unchanged", 32'(trim_code), 32'd32);
    chk("R14 irq with enabled flag", 32'(irq), 32'd1);
    wr(2'd3, 32'hF);
  endtask

  task automatic t_warn_fast;
    logic [31:0] v;
    next_event(0, 13, 1);
    rd(2'd2, v); chk("R3 R5 fast warning status", v, 32'h0003_000A);
    chk("R5 trim down one", 32'(trim_code), 32'd31);
    wr(2'd3, 32'hF);
  endtask

  task automatic t_warn_slow;
    logic [31:0] v;
    next_event(0, 7, 1);
    rd(2'd2, v); chk("R3 R5 slow warning status", v, 32'h0003_8002);
    chk("R5 trim up one", 32'(trim_code), 32'd32);
    wr(2'd3, 32'hF);
  endtask

  task automatic t_miss;
    logic [31:0] v;
    next_event(0, 17, 1);
    rd(2'd2, v); chk("R6 R7 missed and error status", v, 32'h0006_030C);
    chk("R6 trim down two", 32'(trim_code), 32'd30);
    wr(2'd3, 32'h4);
    rd(2'd2, v); chk("R10 error clear keeps others", v, 32'h0006_0008);
    wr(2'd3, 32'hF);
  endtask

  task automatic t_sw;
    logic [31:0] v;
    settle(7);
    wr(2'd0, 32'h0000_20F7);
    rd(2'd2, v); chk("R13 software sync status", v, 32'h0000_8009);
    chk("R13 trim after software sync", 32'(trim_code), 32'd30);
    wr(2'd3, 32'hF);
    wr(2'd0, 32'h0000_05F3);
    chk("R9 trim write ignored at port", 32'(trim_code), 32'd30);
    rd(2'd0, v); chk("R9 control readback", v, 32'h0000_1EF3);
  endtask

  task automatic t_err_fast;
    logic [31:0] v;
    next_event(0, 17, 2);
    rd(2'd2, v); chk("R6 repeated error status", v, 32'h0006_030C);
    chk("R6 trim down two again", 32'(trim_code), 32'd28);
    wr(2'd3, 32'hF);
    wr(2'd0, 32'h0000_3EF1);
    wr(2'd0, 32'h0000_3EF3);
  endtask

  task automatic t_sat_hi;
    logic [31:0] v;
    chk("R9 trim write with auto off", 32'(trim_code), 32'd62);
    next_event(0, 4, 3);
    rd(2'd2, v); chk("R8 upper saturation status", v, 32'h0006_8504);
    chk("R8 trim held at 63", 32'(trim_code), 32'd63);
    wr(2'd3, 32'hF);
    wr(2'd0, 32'h0000_01F1);
    wr(2'd0, 32'h0000_01F3);
  endtask

  task automatic t_sat_lo;
    logic [31:0] v;
    next_event(0, 17, 3);
    rd(2'd2, v); chk("R8 lower saturation status", v, 32'h0006_070C);
    chk("R8 trim held at 0", 32'(trim_code), 32'd0);
    chk("R14 irq set before masking", 32'(irq), 32'd1);
    wr(2'd0, 32'h0000_0003);
    chk("R14 irq masked", 32'(irq), 32'd0);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'h2202_0009);
    wr(2'd0, 32'h0000_00F1);
    pulse(2); settle(2); pulse(2); settle(2); pulse(2); settle(2); pulse(2);
    wr(2'd3, 32'hF);
    pulse(2); settle(2); pulse(2); settle(1); pulse(2); settle(2); pulse(2);
    rd(2'd2, v); chk("R12 divide by four status", v, 32'h0000_8009);
  endtask

  task automatic t_polarity;
    logic [31:0] v;
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'h9002_0009);
    sync_lsx = 1'b1;
    wr(2'd0, 32'h0000_00F1);
    pulse(1);
    wr(2'd3, 32'hF);
    settle(5);
    pulse(0);
    next_event(1, 13, 7);
    rd(2'd2, v); chk("R11 falling crystal source, pin ignored", v, 32'h0003_000A);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; sync_pin = 1'b0; sync_lsx = 1'b0; sync_sof = 1'b0;
    bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    settle(3);
    rst_n = 1'b1;
    settle(4);
    t_reset;
    t_setup;
    t_exact;
    t_warn_fast;
    t_warn_slow;
    t_miss;
    t_sw;
    t_err_fast;
    t_sat_hi;
    t_sat_lo;
    t_prescale;
    t_polarity;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule